// File: doc/BRIEF.md
# Product Term Steering Allocator

This block models the OR plane of one programmable logic block. A shared pool of product-term results comes in from an AND array outside the block. A stored map of enable bits says which of those terms feed each macrocell sum. Every sum output is the OR of the terms enabled for it, so a macrocell may take any number of terms from none up to the per-output limit. One term may feed several sums, provided those sums belong to the same group of four adjacent macrocells.

The map holds one bit for each term/output pair. It is loaded one bit at a time through a synchronous write port that names an output, a term and a value, and reset clears it. The sums are purely combinational in the terms and the stored map. The OR for each output always spans the whole pool, so the path from term to sum does not change with the number of terms steered or shared. Two check flags report a map that breaks the allocation rules: an output with too many terms, or a term used in more than one group.

Top module: `pt_steer_top`

## Requirements
- R1: After reset, and after any later reset, every map bit is clear: all sums are 0 for any term vector, and both error flags are 0.
- R2: Each sum output `sums[o]` equals the OR of `terms[t]` over every term t whose map bit for output o is set.
- R3: An output with no enabled terms holds its sum at 0 whatever the term vector, including all ones.
- R4: A write with `cfgWe` high sets the map bit (`cfgOutSel`, `cfgTermSel`) to `cfgVal` at the rising clock edge. The sums reflect it from that edge on and not before, and writing 0 removes a term.
- R5: `overCountErr` is 1 exactly when some output has more than 16 enabled terms. Exactly 16 on one output is legal.
- R6: One term enabled on several outputs of the same group (outputs 4g to 4g+3) drives all of them, and `crossGroupErr` stays 0.
- R7: `crossGroupErr` is 1 exactly when some term is enabled on outputs of two or more different groups. The sums still follow R2 while it is set.
- R8: A write whose `cfgTermSel` is 80 or above changes no map bit.
- R9: A change on `terms` reaches `sums` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the map write port |
| rstN | input | 1 | Active-low synchronous reset; clears the map |
| cfgWe | input | 1 | Write enable for one map bit |
| cfgOutSel | input | 4 | Output index of the map bit to write |
| cfgTermSel | input | 7 | Term index of the map bit to write (0 to 79 valid) |
| cfgVal | input | 1 | Value to store in the addressed map bit |
| terms | input | 80 | Product-term results from the AND array |
| sums | output | 16 | One OR-plane sum per macrocell |
| overCountErr | output | 1 | Some output has more than 16 enabled terms |
| crossGroupErr | output | 1 | Some term is enabled in more than one group of four |

## Verification
A wrong map bit shows on the ports as soon as the term it covers is driven high or low on its own. The affected sum then differs from the OR of its intended terms in the same cycle, because nothing is registered between map and sum. Any write that lands in the wrong place shows at the first sampling point after the clock edge that stored it. So does a write that lands too early or is lost, either in the sums or in a flag that should not have moved. A corrupted count or group check shows directly on the two flags once the map holds 16 or 17 terms on one output, or one term spans two groups.

// File: rtl/pt_steer_pkg.sv
package pt_steer_pkg;
  // Widest index the strobe struct can carry; top parameters must fit in it.
  localparam int unsigned STROBE_IDX_W = 8;

  typedef struct packed {
    logic                    wr;
    logic                    val;
    logic [STROBE_IDX_W-1:0] outIdx;
    logic [STROBE_IDX_W-1:0] termIdx;
  } cfgStrobe_t;
endpackage

// File: rtl/pt_steer_ctrl.sv
module pt_steer_ctrl
  import pt_steer_pkg::*;
#(
  parameter int unsigned NUM_OUT   = 16,
  parameter int unsigned NUM_TERMS = 80,
  localparam int unsigned OUT_W    = $clog2(NUM_OUT),
  localparam int unsigned TERM_W   = $clog2(NUM_TERMS)
) (
  input  logic              cfgWe,
  input  logic [OUT_W-1:0]  cfgOutSel,
  input  logic [TERM_W-1:0] cfgTermSel,
  input  logic              cfgVal,
  output cfgStrobe_t        strobe
);
  logic termOk;
  logic outOk;

  // Indices past the pool are dropped here so the store never aliases them.
  assign termOk = (32'(cfgTermSel) < NUM_TERMS);
  assign outOk  = (32'(cfgOutSel) < NUM_OUT);

  always_comb begin
    strobe         = '0;
    strobe.wr      = cfgWe && termOk && outOk;
    strobe.val     = cfgVal;
    strobe.outIdx  = STROBE_IDX_W'(cfgOutSel);
    strobe.termIdx = STROBE_IDX_W'(cfgTermSel);
  end
endmodule

// File: rtl/pt_steer_datapath.sv
module pt_steer_datapath
  import pt_steer_pkg::*;
#(
  parameter int unsigned NUM_OUT     = 16,
  parameter int unsigned NUM_TERMS   = 80,
  parameter int unsigned MAX_PER_OUT = 16,
  parameter int unsigned GROUP_SIZE  = 4,
  localparam int unsigned NUM_GROUPS = NUM_OUT / GROUP_SIZE,
  localparam int unsigned OUT_W      = $clog2(NUM_OUT),
  localparam int unsigned TERM_W     = $clog2(NUM_TERMS),
  localparam int unsigned CNT_W      = $clog2(NUM_TERMS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cfgStrobe_t           strobe,
  input  logic [NUM_TERMS-1:0] terms,
  output logic [NUM_OUT-1:0]   sums,
  output logic                 overCountErr,
  output logic                 crossGroupErr
);
  logic [NUM_OUT-1:0][NUM_TERMS-1:0] cfgMem;
  logic [NUM_OUT-1:0]                overFlags;
  logic [NUM_TERMS-1:0]              crossFlags;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgMem <= '0;
    end else if (strobe.wr) begin
      cfgMem[strobe.outIdx[OUT_W-1:0]][strobe.termIdx[TERM_W-1:0]] <= strobe.val;
    end
  end

  // Full-width OR per output: same depth whatever the steering.
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_sum
    assign sums[o] = |(cfgMem[o] & terms);

    always_comb begin
      logic [CNT_W-1:0] cnt;
      cnt = '0;
      for (int t = 0; t < NUM_TERMS; t++) begin
        cnt = cnt + CNT_W'(cfgMem[o][t]);
      end
      overFlags[o] = (32'(cnt) > MAX_PER_OUT);
    end
  end

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_share
    always_comb begin
      logic [NUM_GROUPS-1:0] groupHit;
      groupHit = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
        for (int k = 0; k < GROUP_SIZE; k++) begin
          groupHit[g] = groupHit[g] | cfgMem[g*GROUP_SIZE + k][t];
        end
      end
      crossFlags[t] = (groupHit & (groupHit - 1'b1)) != '0;
    end
  end

  assign overCountErr  = |overFlags;
  assign crossGroupErr = |crossFlags;

  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wr |=> cfgMem[$past(strobe.outIdx[OUT_W-1:0])][$past(strobe.termIdx[TERM_W-1:0])] == $past(strobe.val));

  // R8
  idle_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wr |=> $stable(cfgMem));

  // R5
  count_flag_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(cfgMem) |-> $stable(overCountErr));

  // R7
  share_flag_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(cfgMem) |-> $stable(crossGroupErr));

  // R9
  comb_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(cfgMem) && $stable(terms)) |-> $stable(sums));
endmodule

// File: rtl/pt_steer_top.sv
module pt_steer_top
  import pt_steer_pkg::*;
#(
  parameter int unsigned NUM_OUT     = 16,
  parameter int unsigned NUM_TERMS   = 80,
  parameter int unsigned MAX_PER_OUT = 16,
  parameter int unsigned GROUP_SIZE  = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgWe,
  input  logic [$clog2(NUM_OUT)-1:0]   cfgOutSel,
  input  logic [$clog2(NUM_TERMS)-1:0] cfgTermSel,
  input  logic                         cfgVal,
  input  logic [NUM_TERMS-1:0]         terms,
  output logic [NUM_OUT-1:0]           sums,
  output logic                         overCountErr,
  output logic                         crossGroupErr
);
  cfgStrobe_t strobe;

  pt_steer_ctrl #(
    .NUM_OUT  (NUM_OUT),
    .NUM_TERMS(NUM_TERMS)
  ) u_ctrl (
    .cfgWe     (cfgWe),
    .cfgOutSel (cfgOutSel),
    .cfgTermSel(cfgTermSel),
    .cfgVal    (cfgVal),
    .strobe    (strobe)
  );

  pt_steer_datapath #(
    .NUM_OUT    (NUM_OUT),
    .NUM_TERMS  (NUM_TERMS),
    .MAX_PER_OUT(MAX_PER_OUT),
    .GROUP_SIZE (GROUP_SIZE)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .terms        (terms),
    .sums         (sums),
    .overCountErr (overCountErr),
    .crossGroupErr(crossGroupErr)
  );
endmodule

// File: tb/tb_pt_steer_top.sv
module tb_pt_steer_top;
  localparam int CLK_PERIOD = 10;
  localparam int NO = 16;
  localparam int NT = 80;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [3:0]    cfgOutSel = '0;
  logic [6:0]    cfgTermSel = '0;
  logic          cfgVal = 1'b0;
  logic [NT-1:0] terms = '0;
  logic [NO-1:0] sums;
  logic          overCountErr;
  logic          crossGroupErr;

  logic [NO-1:0][NT-1:0] mdl;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_steer_top dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgOutSel(cfgOutSel),
    .cfgTermSel(cfgTermSel), .cfgVal(cfgVal), .terms(terms), .sums(sums),
    .overCountErr(overCountErr), .crossGroupErr(crossGroupErr)
  );

  function automatic logic [NO-1:0] expSums(logic [NT-1:0] tv);
    logic [NO-1:0] r;
    for (int o = 0; o < NO; o++) r[o] = |(mdl[o] & tv);
    return r;
  endfunction

  task automatic chk(string req, logic [NO-1:0] act, logic [NO-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mdl = '0;
  endtask

  task automatic wrBit(int o, int t, logic v);
    @(negedge clk);
    cfgWe = 1'b1; cfgOutSel = 4'(o); cfgTermSel = 7'(t); cfgVal = v;
    @(posedge clk);
    @(negedge clk);
    cfgWe = 1'b0;
    if (t < NT) mdl[o][t] = v;
  endtask

  task automatic applyCheck(string req, logic [NT-1:0] tv);
    terms = tv;
    #1;
    chk(req, sums, expSums(tv));
  endtask

  task automatic testReset();
    wrBit(3, 5, 1'b1);
    wrBit(8, 70, 1'b1);
    doReset();
    terms = '1;
    #1;
    chk("R1 sums after reset", sums, '0);
    chk("R1 flags after reset", {14'b0, overCountErr, crossGroupErr}, '0);
  endtask

  task automatic testOrPlane();
    wrBit(0, 3, 1'b1); wrBit(0, 7, 1'b1);
    wrBit(5, 79, 1'b1);
    wrBit(15, 0, 1'b1); wrBit(15, 40, 1'b1); wrBit(15, 64, 1'b1);
    applyCheck("R2 none", '0);
    applyCheck("R2 term3", NT'(1) << 3);
    applyCheck("R2 term7", NT'(1) << 7);
    applyCheck("R2 term79", NT'(1) << 79);
    applyCheck("R2 term64", NT'(1) << 64);
    applyCheck("R2 unused term", NT'(1) << 50);
    applyCheck("R2 mixed", (NT'(1) << 40) | (NT'(1) << 3));
  endtask

  task automatic testEmpty();
    terms = '1;
    #1;
    chk("R3 empty outputs stay 0", sums & 16'b0111_1111_1101_1110, '0);
  endtask

  task automatic testWriteTiming();
    terms = NT'(1) << 10;
    @(negedge clk);
    cfgWe = 1'b1; cfgOutSel = 4'd2; cfgTermSel = 7'd10; cfgVal = 1'b1;
    #1;
    chk("R4 not before edge", {15'b0, sums[2]}, 16'd0);
    @(posedge clk);
    #1;
    chk("R4 after edge", {15'b0, sums[2]}, 16'd1);
    @(negedge clk);
    cfgWe = 1'b0;
    mdl[2][10] = 1'b1;
    wrBit(2, 10, 1'b0);
    applyCheck("R4 removed term", NT'(1) << 10);
  endtask

  task automatic testCount();
    doReset();
    for (int t = 0; t < 16; t++) wrBit(12, t, 1'b1);
    #1;
    chk("R5 sixteen legal", {15'b0, overCountErr}, 16'd0);
    applyCheck("R5 term15 on full output", NT'(1) << 15);
    wrBit(12, 16, 1'b1);
    #1;
    chk("R5 seventeen flagged", {15'b0, overCountErr}, 16'd1);
    wrBit(12, 16, 1'b0);
    #1;
    chk("R5 flag clears", {15'b0, overCountErr}, 16'd0);
  endtask

  task automatic testShare();
    doReset();
    for (int o = 4; o < 8; o++) wrBit(o, 20, 1'b1);
    applyCheck("R6 shared in group", NT'(1) << 20);
    chk("R6 group sums high", sums, 16'h00F0);
    chk("R6 no cross flag", {15'b0, crossGroupErr}, 16'd0);
    wrBit(8, 20, 1'b1);
    #1;
    chk("R7 cross flagged", {15'b0, crossGroupErr}, 16'd1);
    applyCheck("R7 sums still follow map", NT'(1) << 20);
    wrBit(8, 20, 1'b0);
    #1;
    chk("R7 cross clears", {15'b0, crossGroupErr}, 16'd0);
  endtask

  task automatic testOutOfRange();
    doReset();
    wrBit(1, 100, 1'b1);
    wrBit(6, 127, 1'b1);
    applyCheck("R8 out-of-range write ignored", '1);
    chk("R8 no flags", {14'b0, overCountErr, crossGroupErr}, '0);
  endtask

  task automatic testComb();
    wrBit(9, 33, 1'b1);
    @(negedge clk);
    #2;
    terms = NT'(1) << 33;
    #1;
    chk("R9 same-cycle rise", {15'b0, sums[9]}, 16'd1);
    terms = '0;
    #1;
    chk("R9 same-cycle fall", {15'b0, sums[9]}, 16'd0);
  endtask

  initial begin
    mdl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testOrPlane();
    testEmpty();
    testWriteTiming();
    testCount();
    testShare();
    testOutOfRange();
    testComb();
    testReset();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule